// File: doc/BRIEF.md
# Clock Source and Oscillator Controller

This block is the clock control logic of a small microcontroller. It drives the enables of two oscillators: a high-speed system oscillator and an internal ring oscillator. It picks which of the two clocks the CPU runs from, and it opens or closes the CPU clock gate and the peripheral prescaler clock gate for each operating mode: run, HALT and STOP. The analog oscillators and the clock multiplexer itself sit outside the block. The block tracks how long each oscillator has been enabled, so it knows when that clock is settled and safe to use.

Software controls the block through a write-only port into three one-bit control fields: the ring stop bit, the CPU clock select bit and the high-speed stop bit. A strap input, fixed at power-up, decides whether software may stop the ring oscillator at all. A write that would ask for both oscillators to stop is refused. HALT keeps both oscillators running and gates only the CPU. STOP also shuts down the high-speed oscillator. A wake event brings the CPU back once its oscillator has settled again.

Top module: `clkctl_top`

## Requirements
- R1: When reset is released, the CPU source is the ring oscillator (`cpu_src` = 0) and the high-speed stop bit is 1, so `hs_osc_en` = 0. `cpu_clk_en` stays 0 until the ring oscillator has settled, and it rises on the (RING_SETTLE+1)-th clock edge after reset is released.
- R2: The register fields are: address 0, bit 0 is the ring stop bit; address 1, bit 0 is the CPU clock select (0 = ring, 1 = high-speed); address 2, bit 7 is the high-speed stop bit (1 = stopped). Any other address, and any other bit of these three registers, has no effect.
- R3: When `ring_stoppable` = 0, `ring_osc_en` stays 1 whatever the ring stop bit holds. When `ring_stoppable` = 1, the ring stop bit gates `ring_osc_en`.
- R4: A write that would leave both the ring stop bit and the high-speed stop bit at 1 is refused, whatever the strap says. Every field keeps its old value, and `wr_err` is 1 in the cycle after that write and only then.
- R5: A stop bit never turns off the oscillator that is the current CPU source.
- R6: `cpu_src` takes the value of the select bit only in run mode, only in a cycle with no HALT or STOP request, and only once the target oscillator has been enabled for its full settle time. The change shows one cycle later.
- R7: One cycle after a HALT request in run mode, `cpu_clk_en` goes to 0 and both oscillator enables stay as they were. `per_clk_en` stays 1, and `per_src` holds the CPU source of the cycle in which the request was taken.
- R8: One cycle after a STOP request in run mode, `cpu_clk_en` = 0 and `hs_osc_en` = 0. `per_clk_en` is 1 only if the held source is the ring oscillator and that oscillator is still running. If STOP and HALT are requested together, STOP wins.
- R9: A `wake` in HALT or STOP returns the block to run mode. The CPU source oscillator is enabled at least one cycle before `cpu_clk_en` rises. After a HALT, `cpu_clk_en` rises on the second edge after `wake`.
- R10: The settle count of an oscillator starts again from zero whenever its enable drops. A high-speed oscillator that is stopped and then restarted can become the CPU source no earlier than HS_SETTLE+1 edges after its enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_stoppable | input | 1 | Power-up strap: 1 lets software stop the ring oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register write data |
| halt_req | input | 1 | HALT request, one cycle |
| stop_req | input | 1 | STOP request, one cycle |
| wake | input | 1 | Wake event from HALT or STOP |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| cpu_src | output | 1 | Source the CPU is actually using (0 ring, 1 high-speed) |
| per_src | output | 1 | Source feeding the peripheral prescaler |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral prescaler clock gate |
| wr_err | output | 1 | Pulse for a refused write |

## Verification
Register writes and HALT/STOP requests show at the outputs one edge after the cycle that carries them. An oscillator enable drops at once when a stop bit or STOP takes effect. A source switch lands SETTLE+1 edges after the target enable rises. A wake from HALT reopens the CPU clock two edges later. The bench applies each stimulus, waits for exactly one rising edge, samples 1 ns later, and compares every output with a cycle model advanced by that same edge. The directed checks count edges from the stimulus edge and sample at the computed edge number, so the result is never read one edge early or late.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [1:0] {
      MODE_RESUME = 2'd0,
      MODE_RUN    = 2'd1,
      MODE_HALT   = 2'd2,
      MODE_STOP   = 2'd3
   } mode_t;

   localparam logic SRC_RING = 1'b0;
   localparam logic SRC_HS   = 1'b1;
   localparam int   NUM_OSC  = 2;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
   parameter int AW        = 2,
   parameter int DW        = 8,
   parameter int ADDR_RING = 0,
   parameter int ADDR_SEL  = 1,
   parameter int ADDR_HS   = 2,
   parameter int RING_BIT  = 0,
   parameter int SEL_BIT   = 0,
   parameter int HS_BIT    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          ring_stop_q,
   output logic          sel_q,
   output logic          hs_stop_q,
   output logic          wr_err_q
);
   localparam int PW = (DW > 1) ? $clog2(DW) : 1;

   logic [PW-1:0] fpos;
   logic          wbit;
   logic          hit_ring, hit_sel, hit_hs;
   logic          nx_ring, nx_sel, nx_hs, refuse;

   assign hit_ring = wr_en && (wr_addr == AW'(ADDR_RING));
   assign hit_sel  = wr_en && (wr_addr == AW'(ADDR_SEL));
   assign hit_hs   = wr_en && (wr_addr == AW'(ADDR_HS));

   // field bit picked by the addressed register
   always_comb begin
      if (wr_addr == AW'(ADDR_HS))       fpos = PW'(HS_BIT);
      else if (wr_addr == AW'(ADDR_SEL)) fpos = PW'(SEL_BIT);
      else                               fpos = PW'(RING_BIT);
   end
   assign wbit = wr_data[fpos];

   assign nx_ring = hit_ring ? wbit : ring_stop_q;
   assign nx_sel  = hit_sel  ? wbit : sel_q;
   assign nx_hs   = hit_hs   ? wbit : hs_stop_q;
   assign refuse  = wr_en && nx_ring && nx_hs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_stop_q <= 1'b0;
         sel_q       <= 1'b0;
         hs_stop_q   <= 1'b1;
         wr_err_q    <= 1'b0;
      end else begin
         wr_err_q <= refuse;
         if (wr_en && !refuse) begin
            ring_stop_q <= nx_ring;
            sel_q       <= nx_sel;
            hs_stop_q   <= nx_hs;
         end
      end
   end
endmodule

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
   parameter int SETTLE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic stable
);
   localparam int CW = $clog2(SETTLE + 1);

   generate
      if (SETTLE < 1) begin : g_bad_settle
         $error("clkctl_settle: SETTLE must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (!en)                   cnt_q <= '0;
      else if (cnt_q != CW'(SETTLE))  cnt_q <= cnt_q + 1'b1;
   end

   assign stable = en && (cnt_q == CW'(SETTLE));
endmodule

// File: rtl/clkctl_seq.sv
module clkctl_seq
   import clkctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_req,
   input  logic       stop_req,
   input  logic       wake,
   input  logic       sel,
   input  logic [1:0] osc_stable,
   output mode_t      mode_q,
   output logic       cpu_src_q,
   output logic       held_src_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_RESUME;
         cpu_src_q  <= SRC_RING;
         held_src_q <= SRC_RING;
      end else begin
         unique case (mode_q)
            MODE_RESUME: if (osc_stable[cpu_src_q]) mode_q <= MODE_RUN;
            MODE_RUN: begin
               if (stop_req) begin
                  mode_q     <= MODE_STOP;
                  held_src_q <= cpu_src_q;
               end else if (halt_req) begin
                  mode_q     <= MODE_HALT;
                  held_src_q <= cpu_src_q;
               end else if (sel != cpu_src_q && osc_stable[sel]) begin
                  cpu_src_q  <= sel;
               end
            end
            MODE_HALT, MODE_STOP: if (wake) mode_q <= MODE_RESUME;
            default: mode_q <= MODE_RESUME;
         endcase
      end
   end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
   import clkctl_pkg::*;
#(
   parameter int AW          = 2,
   parameter int DW          = 8,
   parameter int ADDR_RING   = 0,
   parameter int ADDR_SEL    = 1,
   parameter int ADDR_HS     = 2,
   parameter int RING_BIT    = 0,
   parameter int SEL_BIT     = 0,
   parameter int HS_BIT      = 7,
   parameter int RING_SETTLE = 3,
   parameter int HS_SETTLE   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ring_stoppable,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          halt_req,
   input  logic          stop_req,
   input  logic          wake,
   output logic          hs_osc_en,
   output logic          ring_osc_en,
   output logic          cpu_src,
   output logic          per_src,
   output logic          cpu_clk_en,
   output logic          per_clk_en,
   output logic          wr_err
);
   generate
      if (HS_BIT >= DW || RING_BIT >= DW || SEL_BIT >= DW) begin : g_bad_bits
         $error("clkctl_top: field bit outside data width");
      end
      if (ADDR_RING == ADDR_SEL || ADDR_RING == ADDR_HS || ADDR_SEL == ADDR_HS) begin : g_bad_addr
         $error("clkctl_top: register addresses must differ");
      end
      if (ADDR_RING >= (1 << AW) || ADDR_SEL >= (1 << AW) || ADDR_HS >= (1 << AW)) begin : g_bad_aw
         $error("clkctl_top: address outside address width");
      end
   endgenerate

   logic ring_stop_q, sel_q, hs_stop_q;
   logic held_src_q, cpu_src_q;
   mode_t mode_q;
   logic [NUM_OSC-1:0] osc_on, osc_stable;

   clkctl_regs #(
      .AW(AW), .DW(DW), .ADDR_RING(ADDR_RING), .ADDR_SEL(ADDR_SEL),
      .ADDR_HS(ADDR_HS), .RING_BIT(RING_BIT), .SEL_BIT(SEL_BIT), .HS_BIT(HS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ring_stop_q(ring_stop_q), .sel_q(sel_q), .hs_stop_q(hs_stop_q), .wr_err_q(wr_err)
   );

   clkctl_seq u_seq (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req), .wake(wake),
      .sel(sel_q), .osc_stable(osc_stable), .mode_q(mode_q),
      .cpu_src_q(cpu_src_q), .held_src_q(held_src_q)
   );

   // a stop bit never removes the clock the CPU is running from
   assign hs_osc_en   = (mode_q != MODE_STOP) && (!hs_stop_q || cpu_src_q == SRC_HS);
   assign ring_osc_en = !ring_stoppable || !ring_stop_q || cpu_src_q == SRC_RING;
   assign osc_on      = {hs_osc_en, ring_osc_en};

   generate
      for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
         clkctl_settle #(
            .SETTLE((i == int'(SRC_HS)) ? HS_SETTLE : RING_SETTLE)
         ) u_settle (
            .clk(clk), .rst_n(rst_n), .en(osc_on[i]), .stable(osc_stable[i])
         );
      end
   endgenerate

   assign cpu_src    = cpu_src_q;
   assign per_src    = (mode_q == MODE_RUN) ? cpu_src_q : held_src_q;
   assign cpu_clk_en = (mode_q == MODE_RUN);
   assign per_clk_en = osc_stable[per_src];
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk
   import clkctl_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  ring_stoppable,
   input logic  wr_en,
   input mode_t mode_q,
   input logic  ring_stop_q,
   input logic  hs_stop_q,
   input logic  hs_osc_en,
   input logic  ring_osc_en,
   input logic  cpu_src,
   input logic  cpu_clk_en,
   input logic  per_clk_en,
   input logic  wr_err
);
   // R3
   ring_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ring_stoppable |-> ring_osc_en);

   // R4
   no_both_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_stop_q && hs_stop_q));

   // R4
   err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));

   // R5
   src_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_STOP) |-> (cpu_src ? hs_osc_en : ring_osc_en));

   // R6
   switch_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_src) |-> ($past(cpu_clk_en) && (cpu_src ? $past(hs_osc_en) : $past(ring_osc_en))));

   // R7
   halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HALT) |-> (!cpu_clk_en && per_clk_en));

   // R8
   stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STOP) |-> (!cpu_clk_en && !hs_osc_en));

   // R9
   wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> (cpu_src ? $past(hs_osc_en) : $past(ring_osc_en)));
endmodule

bind clkctl_top clkctl_chk u_clkctl_chk (
   .clk(clk), .rst_n(rst_n), .ring_stoppable(ring_stoppable), .wr_en(wr_en),
   .mode_q(mode_q), .ring_stop_q(ring_stop_q), .hs_stop_q(hs_stop_q),
   .hs_osc_en(hs_osc_en), .ring_osc_en(ring_osc_en), .cpu_src(cpu_src),
   .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wr_err(wr_err)
);

// File: tb/test_clkctl_top.sv
`timescale 1ns/1ps
module test_clkctl_top;
   localparam int RS = 3;
   localparam int HS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic opt = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic halt_req = 1'b0, stop_req = 1'b0, wake = 1'b0;
   logic hs_osc_en, ring_osc_en, cpu_src, per_src, cpu_clk_en, per_clk_en, wr_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clkctl_top #(.RING_SETTLE(RS), .HS_SETTLE(HS)) i_clkctl_top (
      .clk(clk), .rst_n(rst_n), .ring_stoppable(opt), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .halt_req(halt_req), .stop_req(stop_req), .wake(wake),
      .hs_osc_en(hs_osc_en), .ring_osc_en(ring_osc_en), .cpu_src(cpu_src), .per_src(per_src),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wr_err(wr_err)
   );

   // reference model state; mode 0 resume, 1 run, 2 halt, 3 stop
   logic m_rs, m_sel, m_hs, m_src, m_held, m_err;
   int   m_mode;
   int   m_cnt [2];

   function automatic int settle_of(int i);
      return (i == 1) ? HS : RS;
   endfunction

   function automatic logic m_en(int i);
      if (i == 1) return (m_mode != 3) && (!m_hs || m_src);
      return !opt || !m_rs || !m_src;
   endfunction

   function automatic logic m_stab(int i);
      return m_en(i) && (m_cnt[i] == settle_of(i));
   endfunction

   function automatic logic m_psrc();
      return (m_mode == 1) ? m_src : m_held;
   endfunction

   task automatic model_reset();
      m_rs = 0; m_sel = 0; m_hs = 1; m_src = 0; m_held = 0; m_err = 0;
      m_mode = 0; m_cnt[0] = 0; m_cnt[1] = 0;
   endtask

   task automatic model_step();
      logic st0, st1, e0, e1, nrs, nsel, nhs, bad;
      logic st [2];
      st0 = m_stab(0); st1 = m_stab(1); e0 = m_en(0); e1 = m_en(1);
      st[0] = st0; st[1] = st1;
      case (m_mode)
         0: if (st[m_src]) m_mode = 1;
         1: begin
            if (stop_req) begin m_mode = 3; m_held = m_src; end
            else if (halt_req) begin m_mode = 2; m_held = m_src; end
            else if (m_sel != m_src && st[m_sel]) m_src = m_sel;
         end
         default: if (wake) m_mode = 0;
      endcase
      nrs  = (wr_en && wr_addr == 2'd0) ? wr_data[0] : m_rs;
      nsel = (wr_en && wr_addr == 2'd1) ? wr_data[0] : m_sel;
      nhs  = (wr_en && wr_addr == 2'd2) ? wr_data[7] : m_hs;
      bad  = wr_en && nrs && nhs;
      if (wr_en && !bad) begin m_rs = nrs; m_sel = nsel; m_hs = nhs; end
      m_err = bad;
      m_cnt[0] = e0 ? ((m_cnt[0] < RS) ? m_cnt[0] + 1 : RS) : 0;
      m_cnt[1] = e1 ? ((m_cnt[1] < HS) ? m_cnt[1] + 1 : HS) : 0;
   endtask

   task automatic check(string tag, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R8 hs_osc_en",  hs_osc_en,   m_en(1));
      check("R3 ring_osc_en", ring_osc_en, m_en(0));
      check("R6 cpu_src",    cpu_src,     m_src);
      check("R7 per_src",    per_src,     m_psrc());
      check("R7 cpu_clk_en", cpu_clk_en,  m_mode == 1);
      check("R8 per_clk_en", per_clk_en,  m_stab(int'(m_psrc())));
      check("R4 wr_err",     wr_err,      m_err);
   endtask

   task automatic cycle();
      @(posedge clk);
      #1;
      model_step();
      compare_all();
   endtask

   task automatic idle();
      wr_en = 0; halt_req = 0; stop_req = 0; wake = 0;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      cycle();
      idle();
   endtask

   task automatic pulse(int which);
      if (which == 0) halt_req = 1;
      else if (which == 1) stop_req = 1;
      else wake = 1;
      cycle();
      idle();
   endtask

   task automatic do_reset(logic o);
      idle();
      opt = o;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      model_reset();
      rst_n = 1;
   endtask

   task automatic run_random(int n);
      for (int k = 0; k < n; k++) begin
         int r;
         idle();
         r = int'($urandom_range(0, 99));
         if (r < 20) begin
            wr_en = 1;
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = 8'($urandom);
         end
         r = int'($urandom_range(0, 99));
         if (r < 2) stop_req = 1;
         else if (r < 5) halt_req = 1;
         else if (r < 15) wake = 1;
         cycle();
      end
      idle();
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed_c10c);

      // ---- strap: ring cannot be stopped ----
      do_reset(1'b0);
      // R1: ring is the source, hs is off, CPU gate opens on edge RS+1
      for (int k = 1; k <= RS + 1; k++) begin
         cycle();
         check("R1 cpu_clk_en after reset", cpu_clk_en, k == RS + 1);
         if (k == 1) begin
            check("R1 cpu_src at reset", cpu_src, 1'b0);
            check("R1 hs_osc_en at reset", hs_osc_en, 1'b0);
         end
      end
      // R3 + R4: ring stop while hs stopped is refused; ring keeps running
      wr(2'd0, 8'h01);
      check("R4 wr_err after refused write", wr_err, 1'b1);
      check("R3 ring_osc_en strap 0", ring_osc_en, 1'b1);
      cycle();
      check("R4 wr_err single pulse", wr_err, 1'b0);
      // R2: unused address and wrong bit have no effect
      wr(2'd3, 8'hFF);
      check("R2 unused address", hs_osc_en, 1'b0);
      wr(2'd2, 8'h7F);
      check("R2 hs stop bit 7 clear starts hs", hs_osc_en, 1'b1);
      wr(2'd1, 8'h01);
      for (int k = 0; k < 20 && !cpu_src; k++) cycle();
      check("R6 switch to hs", cpu_src, 1'b1);
      // R5: stopping the running hs oscillator is held off
      wr(2'd2, 8'h80);
      check("R5 hs kept while in use", hs_osc_en, 1'b1);
      run_random(3000);

      // ---- strap: ring may be stopped ----
      do_reset(1'b1);
      repeat (RS + 2) cycle();
      wr(2'd0, 8'h01);
      check("R5 ring kept while in use", ring_osc_en, 1'b1);
      wr(2'd2, 8'h00);
      check("R4 hs start accepted", wr_err, 1'b0);
      // R7: HALT
      pulse(0);
      check("R7 cpu gated in halt", cpu_clk_en, 1'b0);
      check("R7 per clock in halt", per_clk_en, 1'b1);
      // R9: wake from halt reopens on second edge
      pulse(2);
      check("R9 still gated one edge after wake", cpu_clk_en, 1'b0);
      cycle();
      check("R9 cpu clock back after wake", cpu_clk_en, 1'b1);
      // R8: STOP wins over HALT
      halt_req = 1; stop_req = 1;
      cycle();
      idle();
      check("R8 hs off in stop", hs_osc_en, 1'b0);
      check("R8 per on ring in stop", per_clk_en, 1'b1);
      pulse(2);
      cycle();
      check("R9 cpu clock back after stop", cpu_clk_en, 1'b1);
      // R10: hs restarted must settle again before it is used
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h80);
      cycle();
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h01);
      for (int j = 2; j <= HS + 1; j++) begin
         cycle();
         check("R10 switch waits for settle", cpu_src, j == HS + 1);
      end
      run_random(3000);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule